// File: doc/BRIEF.md
# Edge/Level Interrupt Request Controller

This block is the line-facing core of a platform interrupt controller. It accepts up to 64 interrupt request lines. Each line can be set up as edge-triggered or level-sensitive, and as active-high or active-low. Each line can be masked. The block drives one registered request output per line toward an upstream interrupt controller. Edge requests stay latched until software clears them with a write-one-to-clear operation. Level requests simply follow the input.

Software updates come in through four write strobes: mask, edge-select, polarity and clear. The four strobes share one 64-bit data word and an 8-bit byte-lane enable. Address decode happens outside the block. The configuration registers are brought out as ports so that the bus side can read them back. A status vector shows the requests that are latched and not masked. A change of mask acts at once. A line that already holds a request is raised or dropped on the same clock edge that updates the mask.

Top module: `irq_req_ctrl`

## Requirements
- R1: After reset, every implemented bit of `mask_q` is 1, and `edge_q`, `pol_q`, `irq_out` and `status` are all 0.
- R2: On a clock edge with `mask_we`, `edge_we` or `pol_we` high, bits 8k..8k+7 of the selected register take `wr_data` for each byte lane k where `wr_be[k]`=1. Bits in lanes with `wr_be[k]`=0 keep their value. A register whose strobe is low is unchanged.
- R3: `edge_q[i]`=1 makes line i edge-triggered and 0 makes it level-sensitive. A level line's request equals its active level sampled at each clock edge. Its `irq_out[i]` is 1 after an edge where that level was 1 and the line was unmasked.
- R4: The active level of line i is `irq_in[i]` XOR `pol_q[i]`, so `pol_q[i]`=1 makes the line active-low. The polarity that applies is the one held before the sampling edge.
- R5: An edge line latches its request on an edge where its active level is 1 and the level sampled at the previous edge was 0. That previous level is taken as 0 right after reset. The latched request stays after the input returns to 0.
- R6: After each clock edge, `irq_out[i]` equals the line's request AND NOT the new mask bit. Masking a latched line drops its output on the edge that writes the mask. Unmasking it raises the output on that same edge. An edge request is kept while the line is masked.
- R7: When `clr_we` is high, each bit that is set in `wr_data` and lies in an enabled byte lane clears the request and the output of that line, but only if `edge_q` has that line configured as edge. A new rising level on the same edge wins over the clear.
- R8: `status` equals the latched request vector AND NOT `mask_q`.
- R9: `NUM_LINES` is 1 to 64. Data bits and clear bits at or above `NUM_LINES` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt request lines |
| mask_we | input | 1 | Write strobe for the mask register |
| edge_we | input | 1 | Write strobe for the edge-select register |
| pol_we | input | 1 | Write strobe for the polarity register |
| clr_we | input | 1 | Write-one-to-clear strobe for edge requests |
| wr_data | input | 64 | Write data shared by all strobes |
| wr_be | input | 8 | Byte-lane enables for the write |
| irq_out | output | NUM_LINES | Per-line request outputs toward the upstream controller |
| status | output | NUM_LINES | Pending, unmasked requests |
| mask_q | output | NUM_LINES | Mask register (1 = masked) |
| edge_q | output | NUM_LINES | Edge-select register (1 = edge) |
| pol_q | output | NUM_LINES | Polarity register (1 = active-low) |

## Verification
Sparse random toggling of the input lines, together with random byte-enabled writes, is checked against a bench model on every cycle. This shows whether the request state follows the right rule for each line's mode, polarity and mask. Directed sequences cover the cases that random stimulus reaches only rarely. A single-lane mask write shows whether the byte lanes merge correctly. A pulse on an edge line, followed by a mask and an unmask, shows the difference between a latched request and one that follows the level. A clear aimed at a level line while its input is held high must leave that line alone. A clear on an edge line must drop it, and a clear that lands on the same edge as a new rise shows whether set wins over clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int BUS_W  = 64;
  localparam int LANE_W = 8;
  localparam int LANES  = BUS_W / LANE_W;

  // Spread one enable bit per byte lane over the full bus width.
  function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [BUS_W-1:0] r;
    for (int b = 0; b < BUS_W; b++) begin
      r[b] = be[b / LANE_W];
    end
    return r;
  endfunction

endpackage

// File: rtl/irqc_cfg_reg.sv
module irqc_cfg_reg
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter bit RST_ONES  = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [BUS_W-1:0]       wr_data,
  input  logic [LANES-1:0]       wr_be,
  output logic [NUM_LINES-1:0]   q,
  output logic [NUM_LINES-1:0]   q_nx
);

  logic [BUS_W-1:0]     lane_full;
  logic [NUM_LINES-1:0] lane_sel;
  logic [NUM_LINES-1:0] merged;

  always_comb begin
    lane_full = lane_bits(wr_be);
    lane_sel  = lane_full[NUM_LINES-1:0];
    merged    = (q & ~lane_sel) | (wr_data[NUM_LINES-1:0] & lane_sel);
    q_nx      = we ? merged : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_ONES ? {NUM_LINES{1'b1}} : {NUM_LINES{1'b0}};
    end else if (we) begin
      q <= merged;
    end
  end

  // R2
  no_lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wr_be == '0)) |=> $stable(q));

  // R2
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic pol_cur,
  input  logic edge_cur,
  input  logic mask_cur,
  input  logic mask_nx,
  input  logic clr_bit,
  output logic req_q,
  output logic out_q
);

  logic act;
  logic prev_q;
  logic rise;
  logic clr_hit;
  logic req_nx;
  logic out_nx;

  // Next-state logic
  always_comb begin
    act     = irq_raw ^ pol_cur;
    rise    = act & ~prev_q;
    clr_hit = clr_bit & edge_cur;
    if (edge_cur) begin
      req_nx = (req_q & ~clr_hit) | rise;
    end else begin
      req_nx = act;
    end
    out_nx = req_nx & ~mask_nx;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      prev_q <= act;
      req_q  <= req_nx;
      out_q  <= out_nx;
    end
  end

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_q && mask_cur));

  // R5
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cur && act && !prev_q && !mask_nx) |=> out_q);

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cur && req_q && !clr_bit) |=> req_q);

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_cur |=> (req_q == $past(act)));

endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 mask_we,
  input  logic                 edge_we,
  input  logic                 pol_we,
  input  logic                 clr_we,
  input  logic [BUS_W-1:0]     wr_data,
  input  logic [LANES-1:0]     wr_be,
  output logic [NUM_LINES-1:0] irq_out,
  output logic [NUM_LINES-1:0] status,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] edge_q,
  output logic [NUM_LINES-1:0] pol_q
);

  // R9: line count must lie in 1..64
  generate
    if (NUM_LINES < 1 || NUM_LINES > BUS_W) begin : g_bad_cfg
      $error("irq_req_ctrl: NUM_LINES out of range");
    end
  endgenerate

  logic [NUM_LINES-1:0] mask_nx;
  logic [NUM_LINES-1:0] edge_nx;
  logic [NUM_LINES-1:0] pol_nx;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] req_vec;
  logic [BUS_W-1:0]     clr_lanes;

  // R1: mask resets to all ones, the others to zero
  irqc_cfg_reg #(.NUM_LINES(NUM_LINES), .RST_ONES(1'b1)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wr_data(wr_data),
    .wr_be(wr_be), .q(mask_q), .q_nx(mask_nx));

  irqc_cfg_reg #(.NUM_LINES(NUM_LINES), .RST_ONES(1'b0)) u_edge (
    .clk(clk), .rst_n(rst_n), .we(edge_we), .wr_data(wr_data),
    .wr_be(wr_be), .q(edge_q), .q_nx(edge_nx));

  irqc_cfg_reg #(.NUM_LINES(NUM_LINES), .RST_ONES(1'b0)) u_pol (
    .clk(clk), .rst_n(rst_n), .we(pol_we), .wr_data(wr_data),
    .wr_be(wr_be), .q(pol_q), .q_nx(pol_nx));

  // Clear vector: enabled lanes only, implemented lines only
  always_comb begin
    clr_lanes = wr_data & lane_bits(wr_be);
    clr_vec   = clr_we ? clr_lanes[NUM_LINES-1:0] : {NUM_LINES{1'b0}};
  end

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      irqc_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_raw  (irq_in[i]),
        .pol_cur  (pol_q[i]),
        .edge_cur (edge_q[i]),
        .mask_cur (mask_q[i]),
        .mask_nx  (mask_nx[i]),
        .clr_bit  (clr_vec[i]),
        .req_q    (req_vec[i]),
        .out_q    (irq_out[i]));
    end
  endgenerate

  // R8
  assign status = req_vec & ~mask_q;

  // R6: configuration next-state agrees with the register one edge later
  edge_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (edge_q == $past(edge_nx)));

  // R4
  pol_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pol_q == $past(pol_nx)));

endmodule

// File: tb/irq_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_req_ctrl_tb_top;

  localparam int N = 40;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic          mask_we, edge_we, pol_we, clr_we;
  logic [63:0]   wr_data;
  logic [7:0]    wr_be;
  logic [N-1:0]  irq_out, status, mask_q, edge_q, pol_q;

  int n_cmp;
  int n_bad;
  int cyc;
  bit finished;

  // bench model state
  logic [N-1:0] m_mask, m_edge, m_pol, m_prev, m_req, m_out;

  irq_req_ctrl #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .mask_we(mask_we), .edge_we(edge_we), .pol_we(pol_we), .clr_we(clr_we),
    .wr_data(wr_data), .wr_be(wr_be),
    .irq_out(irq_out), .status(status),
    .mask_q(mask_q), .edge_q(edge_q), .pol_q(pol_q));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] lanes64(input logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 64; b++) r[b] = be[b/8];
    return r;
  endfunction

  function automatic logic [N-1:0] merge(input logic [N-1:0] old,
                                         input logic [63:0] d,
                                         input logic [7:0] be);
    logic [63:0] l;
    l = lanes64(be);
    return (old & ~l[N-1:0]) | (d[N-1:0] & l[N-1:0]);
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "irq_out", irq_out, m_out);
    cmp("R8", "status", status, m_req & ~m_mask);
    cmp(tag, "mask_q", mask_q, m_mask);
    cmp(tag, "edge_q", edge_q, m_edge);
    cmp(tag, "pol_q", pol_q, m_pol);
  endtask

  // One clock: predict from present inputs, clock, compare after the edge.
  task automatic step(input string tag);
    logic [N-1:0] act, rise, clrh, rq, nmask;
    logic [63:0]  cl;
    act  = irq_in ^ m_pol;
    rise = act & ~m_prev;
    cl   = wr_data & lanes64(wr_be);
    clrh = clr_we ? (cl[N-1:0] & m_edge) : '0;
    for (int i = 0; i < N; i++)
      rq[i] = m_edge[i] ? ((m_req[i] & ~clrh[i]) | rise[i]) : act[i];
    nmask = mask_we ? merge(m_mask, wr_data, wr_be) : m_mask;
    @(posedge clk);
    #1;
    m_prev = act;
    m_req  = rq;
    m_mask = nmask;
    if (edge_we) m_edge = merge(m_edge, wr_data, wr_be);
    if (pol_we)  m_pol  = merge(m_pol, wr_data, wr_be);
    m_out = rq & ~nmask;
    check_all(tag);
  endtask

  task automatic wr(input int kind, input logic [63:0] d, input logic [7:0] be,
                    input string tag);
    wr_data = d;
    wr_be   = be;
    mask_we = (kind == 0);
    edge_we = (kind == 1);
    pol_we  = (kind == 2);
    clr_we  = (kind == 3);
    step(tag);
    {mask_we, edge_we, pol_we, clr_we} = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // watchdog
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        summary();
        $finish;
      end
    end
  end

  initial begin
    finished = 1'b0;
    n_cmp = 0; n_bad = 0;
    void'($urandom(32'h5eed_1a2b));
    rst_n = 1'b0;
    irq_in = '0;
    {mask_we, edge_we, pol_we, clr_we} = '0;
    wr_data = '0; wr_be = '0;
    m_mask = '1; m_edge = '0; m_pol = '0; m_prev = '0; m_req = '0; m_out = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check_all("R1");
    step("R1");

    // R2 single-lane mask write, then lanes above N ignored (R9)
    wr(0, 64'h0, 8'h01, "R2");
    wr(0, 64'hFFFF_FFFF_FFFF_FF00, 8'hFE, "R2");
    wr(0, 64'h0, 8'hFF, "R9");

    // R3 level line follows input
    irq_in[2] = 1'b1; step("R3");
    step("R3");
    irq_in[2] = 1'b0; step("R3");

    // R4 active-low line
    wr(2, 64'h20, 8'h01, "R4");
    step("R4");
    irq_in[5] = 1'b1; step("R4");
    wr(2, 64'h0, 8'h01, "R4");

    // R5 edge latch survives input drop
    wr(1, 64'h0C00, 8'h02, "R5");
    irq_in[10] = 1'b1; step("R5");
    irq_in[10] = 1'b0; step("R5");
    step("R5");

    // R6 mask drops, unmask restores latched request
    wr(0, 64'h0400, 8'h02, "R6");
    step("R6");
    wr(0, 64'h0, 8'h02, "R6");

    // R7 clear on level line ignored, on edge line effective
    irq_in[2] = 1'b1; step("R7");
    wr(3, 64'h04, 8'h01, "R7");
    wr(3, 64'h0400, 8'h00, "R7");
    wr(3, 64'h0400, 8'h02, "R7");
    irq_in[11] = 1'b1;
    wr(3, 64'h0800, 8'h02, "R7");
    irq_in[11] = 1'b0; step("R7");
    // clear aimed above N (R9)
    wr(3, 64'hFFFF_FF00_0000_0000, 8'hFF, "R9");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      irq_in = irq_in ^ (N'($urandom()) & N'($urandom()) & N'($urandom()));
      wr_data = {$urandom(), $urandom()};
      wr_be   = 8'($urandom());
      mask_we = ($urandom_range(0, 7) == 0);
      edge_we = ($urandom_range(0, 11) == 0);
      pol_we  = ($urandom_range(0, 15) == 0);
      clr_we  = ($urandom_range(0, 5) == 0);
      step("R6");
      {mask_we, edge_we, pol_we, clr_we} = '0;
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule